// File: doc/BRIEF.md
# Synchronized Three-Phase Center-Aligned PWM Timebase

This block generates three center-aligned PWM waveforms for a three-phase bridge. Each phase owns a triangle counter that climbs from zero to a programmed period and falls back to zero. It also owns a compare value and a level generator. A clock enable, derived from the system clock by a selectable power-of-two divider, paces all three counters. As a result, a full carrier cycle lasts twice the period in ticks. For example, a period of 800 gives 1600 ticks.

Channel 0 is the master. Each time its counter comes back down to zero, it issues a one-cycle sync pulse. Channels 1 and 2 are slaves, and the pulse is chained through them. On that pulse each slave reloads its counter from a shared phase offset and starts counting up. Compare values and the period are written into shadow registers. Each channel copies them into its working registers only on the tick that leaves zero, or at any time while the block is stopped. Because of this, a duty update never splits a carrier cycle.

An interrupt flag is raised on every third return of the master to zero, and it stays set until software clears it. A global run input holds everything at zero while it is low. When run rises, all three counters start in the same clock.

Top module: `cpwm_timebase`

## Requirements
- R1: After reset every counter reads 0 and every PWM output is low, because the working compare resets to all ones. The irq output is low, and the working period is PRD_RST (800).
- R2: Each counter advances by one per tick. It counts up from 0 to the working period P, then down to 0, so a carrier cycle has 2·P ticks. The period may be 1 or larger.
- R3: A tick occurs once every 2·2^div_sel clock cycles. The first tick after run rises comes 2·2^div_sel cycles later, and counters change only on ticks.
- R4: A write strobe for a compare channel (or for the period) updates only a shadow copy. A channel copies both shadows into its working registers on the tick where its counter is 0, or on any cycle while run is low. The working period is the one the step in that same tick uses.
- R5: For a working compare C with 0 < C < P, the output is high exactly while counter ≥ C. It therefore rises at the up-count match and falls after the down-count match.
- R6: A working compare of 0 keeps the output constantly high. A working compare ≥ P keeps it constantly low, including at the counter turning points.
- R7: On the tick where the master counter steps from 1 down to 0, a sync pulse passes through every slave in the same cycle. Each slave ignores its own step, loads phase_val and counts up. The master never reloads. phase_val is expected to be below P.
- R8: irq rises on the EVT_N-th (3rd) master arrival at zero that occurs while irq is low. Arrivals are counted from run's rise or from the previous request.
- R9: irq holds until an irq_clr pulse. Arrivals while irq is high are not counted. If a clear coincides with an arrival while irq is high, the arrival is lost. If a clear coincides with the completing arrival while irq is low, irq still rises.
- R10: While run is low, the counters, tick divider and arrival count are held at zero. After run rises, all three counters step in the same cycle, and with a phase of 0 they stay equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Global enable; low holds the timebase at zero |
| div_sel | input | SELW (3) | Tick divider select, divide by 2·2^div_sel |
| prd_wr | input | 1 | Period shadow write strobe |
| prd_val | input | CW (12) | Period value to write |
| phase_val | input | CW (12) | Counter value slaves load on sync |
| cmp_wr | input | NCH (3) | Per-channel compare shadow write strobes |
| cmp_val | input | NCH·CW (36) | Compare values, channel n in bits n·CW upward |
| irq_clr | input | 1 | Clears the interrupt flag |
| pwm_out | output | NCH (3) | Raw PWM levels, bit n for channel n |
| cnt_out | output | NCH·CW (36) | Counter values, channel n in bits n·CW upward |
| irq | output | 1 | Interrupt request flag |

## Verification
Two pairs of functions can collide in one clock. The first pair is the interrupt clear and the master's completing zero arrival. The second pair is a compare write and the commit tick at zero. The bench uses its reference model to predict the cycle in which the master will step from 1 to 0. It pulses irq_clr exactly there, once with the flag low and once with it high. It then judges irq over the following cycles against the rule in R9. Randomized period, compare, phase and divider changes are written at arbitrary counter positions. Every cycle, the PWM levels and counters are compared with the model, which commits shadows only at zero.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

  typedef enum logic {
    DIR_DN = 1'b0,
    DIR_UP = 1'b1
  } dir_e;

  // clocks between ticks for a given divider select
  function automatic int unsigned tick_span(input int unsigned sel);
    return 32'd2 << sel;
  endfunction

endpackage

// File: rtl/cpwm_prescale.sv
module cpwm_prescale
  import cpwm_pkg::*;
#(
  parameter int SELW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [SELW-1:0] div_sel,
  output logic            tick
);
  localparam int DW = 2 ** SELW;

  logic [DW-1:0] div_q;
  logic [DW-1:0] limit;

  assign limit = DW'(tick_span(32'(div_sel)) - 1);
  assign tick  = run && (div_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else if (!run || tick) div_q <= '0;
    else div_q <= div_q + 1'b1;
  end

  // R3
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/cpwm_channel.sv
module cpwm_channel
  import cpwm_pkg::*;
#(
  parameter int              CW        = 12,
  parameter bit              IS_MASTER = 1'b0,
  parameter logic [CW-1:0]   PRD_RST   = 800
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic [CW-1:0] prd_sh,
  input  logic          cmp_wr,
  input  logic [CW-1:0] cmp_val,
  input  logic [CW-1:0] phase,
  input  logic          sync_in,
  output logic          sync_out,
  output logic [CW-1:0] cnt,
  output logic          pwm
);
  // next {dir, count} of a triangle counter
  function automatic logic [CW:0] tri_step(input logic [CW-1:0] c,
                                           input dir_e d,
                                           input logic [CW-1:0] p);
    logic [CW-1:0] n;
    if (d == DIR_UP) begin
      n = c + 1'b1;
      return {(n < p), n};
    end
    n = c - 1'b1;
    return {(n == '0), n};
  endfunction

  // output level for a counter position and working compare
  function automatic logic lvl(input logic [CW-1:0] c,
                               input logic [CW-1:0] k,
                               input logic [CW-1:0] p);
    if (k == '0) return 1'b1;
    if (k >= p)  return 1'b0;
    return c >= k;
  endfunction

  logic [CW-1:0] cnt_q, cmp_sh_q, cmp_act_q, prd_act_q;
  dir_e          dir_q;

  logic          at_zero, commit, arrive_zero, sync_take;
  logic [CW-1:0] prd_use;
  logic [CW:0]   nxt;

  assign at_zero     = (cnt_q == '0);
  assign commit      = !run || (tick && at_zero);
  assign arrive_zero = tick && (dir_q == DIR_DN) && (cnt_q == CW'(1));
  assign sync_take   = !IS_MASTER && sync_in;
  assign prd_use     = commit ? prd_sh : prd_act_q;
  assign nxt         = tri_step(cnt_q, dir_q, prd_use);

  generate
    if (IS_MASTER) begin : g_src
      assign sync_out = arrive_zero;
    end else begin : g_pass
      assign sync_out = sync_in;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      dir_q     <= DIR_UP;
      cmp_sh_q  <= '1;
      cmp_act_q <= '1;
      prd_act_q <= PRD_RST;
    end else begin
      if (cmp_wr) cmp_sh_q <= cmp_val;
      if (commit) begin
        cmp_act_q <= cmp_sh_q;
        prd_act_q <= prd_sh;
      end
      if (!run) begin
        cnt_q <= '0;
        dir_q <= DIR_UP;
      end else if (tick) begin
        if (sync_take) begin
          cnt_q <= phase;
          dir_q <= DIR_UP;
        end else begin
          cnt_q <= nxt[CW-1:0];
          dir_q <= dir_e'(nxt[CW]);
        end
      end
    end
  end

  assign cnt = cnt_q;
  assign pwm = lvl(cnt_q, cmp_act_q, prd_act_q);

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !sync_take) |=>
      ((cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == $past(cnt_q) - 1'b1)));
  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(cnt_q));
  // R4
  cmp_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !at_zero) |=> $stable(cmp_act_q));
endmodule

// File: rtl/cpwm_evtirq.sv
module cpwm_evtirq #(
  parameter int EVT_N = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic evt,
  input  logic clr,
  output logic irq
);
  localparam int EW = $clog2(EVT_N + 1);

  logic [EW-1:0] ev_q;
  logic          irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      if (clr) irq_q <= 1'b0;
      if (!run) ev_q <= '0;
      else if (evt && !irq_q) begin
        if (ev_q == EW'(EVT_N - 1)) begin
          ev_q  <= '0;
          irq_q <= 1'b1;
        end else begin
          ev_q <= ev_q + 1'b1;
        end
      end
    end
  end

  assign irq = irq_q;

  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_q && !evt) |=> !irq_q);
  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !clr) |=> irq_q);
endmodule

// File: rtl/cpwm_timebase.sv
module cpwm_timebase
  import cpwm_pkg::*;
#(
  parameter int            NCH     = 3,
  parameter int            CW      = 12,
  parameter int            SELW    = 3,
  parameter int            EVT_N   = 3,
  parameter logic [CW-1:0] PRD_RST = 800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [SELW-1:0]   div_sel,
  input  logic              prd_wr,
  input  logic [CW-1:0]     prd_val,
  input  logic [CW-1:0]     phase_val,
  input  logic [NCH-1:0]    cmp_wr,
  input  logic [NCH*CW-1:0] cmp_val,
  input  logic              irq_clr,
  output logic [NCH-1:0]    pwm_out,
  output logic [NCH*CW-1:0] cnt_out,
  output logic              irq
);
  logic          tick;
  logic [CW-1:0] prd_sh_q;
  logic [NCH-1:0] sync_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prd_sh_q <= PRD_RST;
    else if (prd_wr) prd_sh_q <= prd_val;
  end

  cpwm_prescale #(.SELW(SELW)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(run), .div_sel(div_sel), .tick(tick)
  );

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      logic sync_i;
      if (g == 0) begin : g_m
        assign sync_i = 1'b0;
      end else begin : g_s
        assign sync_i = sync_o[g-1];
      end
      cpwm_channel #(.CW(CW), .IS_MASTER(g == 0), .PRD_RST(PRD_RST)) u_ch (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .prd_sh(prd_sh_q),
        .cmp_wr(cmp_wr[g]), .cmp_val(cmp_val[g*CW +: CW]), .phase(phase_val),
        .sync_in(sync_i), .sync_out(sync_o[g]),
        .cnt(cnt_out[g*CW +: CW]), .pwm(pwm_out[g])
      );
    end
  endgenerate

  cpwm_evtirq #(.EVT_N(EVT_N)) u_irq (
    .clk(clk), .rst_n(rst_n), .run(run), .evt(sync_o[0]), .clr(irq_clr), .irq(irq)
  );

  // R7
  sync_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o[NCH-1] == sync_o[0]);
  generate
    if (NCH > 1) begin : g_phchk
      // R7
      slave_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o[0] |=> (cnt_out[CW +: CW] == $past(phase_val)));
    end
  endgenerate
endmodule

// File: tb/cpwm_timebase_tb.sv
module cpwm_timebase_tb;
  localparam int NCH = 3;
  localparam int CW  = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              run = 1'b0;
  logic [2:0]        div_sel = '0;
  logic              prd_wr = 1'b0;
  logic [CW-1:0]     prd_val = '0;
  logic [CW-1:0]     phase_val = '0;
  logic [NCH-1:0]    cmp_wr = '0;
  logic [NCH*CW-1:0] cmp_val = '0;
  logic              irq_clr = 1'b0;
  logic [NCH-1:0]    pwm_out;
  logic [NCH*CW-1:0] cnt_out;
  logic              irq;

  always #10 clk = ~clk;

  cpwm_timebase u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .div_sel(div_sel), .prd_wr(prd_wr),
    .prd_val(prd_val), .phase_val(phase_val), .cmp_wr(cmp_wr), .cmp_val(cmp_val),
    .irq_clr(irq_clr), .pwm_out(pwm_out), .cnt_out(cnt_out), .irq(irq)
  );

  int n_chk = 0, n_bad = 0, n_cyc = 0;
  bit done = 0;

  // reference state
  int m_cnt[NCH], m_up[NCH], m_csh[NCH], m_cact[NCH], m_pact[NCH];
  int m_psh, m_div, m_ev, m_flag;

  function automatic bit exp_lvl(int c, int k, int p);
    if (k == 0) return 1'b1;
    return (k < p) && (c >= k);
  endfunction

  function automatic bit m_tick();
    return run && ((m_div + 1) >= (1 << (div_sel + 1)));
  endfunction

  function automatic bit m_sync_now();
    return m_tick() && m_up[0] == 0 && m_cnt[0] == 1;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NCH; i++) begin
      m_cnt[i] = 0; m_up[i] = 1; m_csh[i] = 4095; m_cact[i] = 4095; m_pact[i] = 800;
    end
    m_psh = 800; m_div = 0; m_ev = 0; m_flag = 0;
  endtask

  task automatic compare_all();
    for (int i = 0; i < NCH; i++) begin
      int a = int'(cnt_out[i*CW +: CW]);
      int k = m_cact[i];
      chk(a == m_cnt[i], (i == 0) ? "R2" : "R7", $sformatf("cnt%0d", i), a, m_cnt[i]);
      chk(pwm_out[i] == exp_lvl(m_cnt[i], k, m_pact[i]),
          (k == 0 || k >= m_pact[i]) ? "R6" : "R5", $sformatf("pwm%0d", i),
          int'(pwm_out[i]), int'(exp_lvl(m_cnt[i], k, m_pact[i])));
    end
    chk(irq == m_flag[0], "R8", "irq", int'(irq), m_flag);
  endtask

  task automatic model_advance();
    bit tk, sy, setf;
    int ncnt[NCH], nup[NCH];
    tk = m_tick();
    sy = m_sync_now();
    for (int i = 0; i < NCH; i++) begin
      bit cm = !run || (tk && m_cnt[i] == 0);
      int pe = cm ? m_psh : m_pact[i];
      ncnt[i] = m_cnt[i]; nup[i] = m_up[i];
      if (!run) begin ncnt[i] = 0; nup[i] = 1; end
      else if (tk) begin
        if (i > 0 && sy) begin ncnt[i] = int'(phase_val); nup[i] = 1; end
        else if (m_up[i] == 1) begin ncnt[i] = m_cnt[i] + 1; nup[i] = (ncnt[i] < pe); end
        else begin ncnt[i] = m_cnt[i] - 1; nup[i] = (ncnt[i] == 0); end
      end
      if (cm) begin m_cact[i] = m_csh[i]; m_pact[i] = m_psh; end
      if (cmp_wr[i]) m_csh[i] = int'(cmp_val[i*CW +: CW]);
    end
    for (int i = 0; i < NCH; i++) begin m_cnt[i] = ncnt[i]; m_up[i] = nup[i]; end
    setf = 0;
    if (!run) m_ev = 0;
    else if (sy && m_flag == 0) begin
      if (m_ev == 2) begin m_ev = 0; setf = 1; end
      else m_ev = m_ev + 1;
    end
    if (irq_clr) m_flag = 0;
    if (setf) m_flag = 1;
    m_div = (!run || tk) ? 0 : m_div + 1;
    if (prd_wr) m_psh = int'(prd_val);
  endtask

  task automatic cyc();
    compare_all();
    model_advance();
    @(posedge clk);
    @(negedge clk);
    prd_wr = 0; cmp_wr = '0; irq_clr = 0;
  endtask

  task automatic wr_cmp(int ch, int v);
    cmp_wr[ch] = 1'b1;
    cmp_val[ch*CW +: CW] = CW'(v);
  endtask

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 150000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: cycles got %0d expected %0d", n_cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(cnt_out == '0, "R1", "cnt_out", int'(cnt_out[CW-1:0]), 0);
    chk(pwm_out == '0, "R1", "pwm_out", int'(pwm_out), 0);
    chk(irq == 1'b0, "R1", "irq", int'(irq), 0);

    // program while stopped: commit happens immediately (R4)
    prd_wr = 1; prd_val = 10;
    wr_cmp(0, 3); wr_cmp(1, 5); wr_cmp(2, 7);
    cyc(); cyc(); cyc();
    chk(pwm_out == 3'b000, "R4", "pwm at cnt0", int'(pwm_out), 0);

    // R3 / R10: start with divide-by-8
    div_sel = 3'd2; run = 1;
    for (int i = 0; i < 7; i++) cyc();
    chk(cnt_out[CW-1:0] == 0, "R3", "cnt0 before 8th clock", int'(cnt_out[CW-1:0]), 0);
    cyc();
    chk(cnt_out[CW-1:0] == 1, "R3", "cnt0 at 8th clock", int'(cnt_out[CW-1:0]), 1);
    chk(cnt_out[CW +: CW] == 1 && cnt_out[2*CW +: CW] == 1, "R10", "slaves aligned",
        int'(cnt_out[2*CW +: CW]), 1);
    for (int i = 0; i < 200; i++) cyc();

    // random segments
    for (int s = 0; s < 24; s++) begin
      int p = 4 + int'($urandom_range(12));
      div_sel = 3'($urandom_range(1));
      phase_val = CW'($urandom_range(3));
      if (s % 3 == 0) begin prd_wr = 1; prd_val = CW'(p); end
      for (int i = 0; i < NCH; i++) begin
        int r = int'($urandom_range(9));
        wr_cmp(i, (r == 0) ? 0 : (r == 1) ? p + 2 : int'($urandom_range(p)));
      end
      for (int i = 0; i < 400; i++) begin
        if ($urandom_range(60) == 0) irq_clr = 1;
        if ($urandom_range(90) == 0) wr_cmp(int'($urandom_range(2)), int'($urandom_range(18)));
        cyc();
      end
    end

    // R4 directed: write mid-cycle, old value stays active until zero
    phase_val = 0; div_sel = 0; prd_wr = 1; prd_val = 12; wr_cmp(0, 4);
    cyc();
    for (int i = 0; i < 200 && !(m_cnt[0] == 6 && m_up[0] == 1 && m_cact[0] == 4); i++) cyc();
    wr_cmp(0, 9);
    cyc(); cyc();
    chk(pwm_out[0] == 1'b1, "R4", "pwm0 with old compare", int'(pwm_out[0]), 1);
    for (int i = 0; i < 200 && m_cact[0] != 9; i++) cyc();
    chk(m_cnt[0] <= 1 && pwm_out[0] == 1'b0, "R4", "pwm0 after commit", int'(pwm_out[0]), 0);

    // R9: flag holds, clear, coincident cases
    irq_clr = 1; cyc();
    for (int i = 0; i < 2000 && m_flag == 0; i++) cyc();
    for (int i = 0; i < 150; i++) cyc();
    chk(irq == 1'b1, "R9", "irq held", int'(irq), 1);
    irq_clr = 1; cyc();
    chk(irq == 1'b0, "R9", "irq cleared", int'(irq), 0);
    for (int i = 0; i < 2000 && !(m_sync_now() && m_ev == 2 && m_flag == 0); i++) cyc();
    irq_clr = 1; cyc();
    chk(irq == 1'b1, "R9", "completing arrival beats clear", int'(irq), 1);
    for (int i = 0; i < 2000 && !m_sync_now(); i++) cyc();
    irq_clr = 1; cyc();
    chk(irq == 1'b0, "R9", "arrival lost while set", int'(irq), 0);
    for (int i = 0; i < 2000 && !m_sync_now(); i++) cyc();
    cyc(); cyc();
    chk(irq == 1'b0, "R9", "one arrival not enough", int'(irq), 0);
    for (int i = 0; i < 300; i++) cyc();

    // R10: stop mid-count
    run = 0; cyc();
    chk(cnt_out == '0, "R10", "cnt_out after stop", int'(cnt_out[CW-1:0]), 0);
    cyc();
    run = 1;
    for (int i = 0; i < 100; i++) cyc();
    chk(cnt_out[CW-1:0] == cnt_out[CW +: CW] && cnt_out[CW-1:0] == cnt_out[2*CW +: CW],
        "R10", "aligned after restart", int'(cnt_out[CW +: CW]), int'(cnt_out[CW-1:0]));

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule